// File: doc/BRIEF.md
# Scoreboard Dynamic Instruction Scheduler

This block is the central hazard controller for an out-of-order execution cluster. Instructions come in program order, one per cycle at most. Each instruction carries an operation class, a destination register and two source registers. The scheduler places each instruction on a free functional unit of the matching class. It then decides, on every cycle, which units may read their operands and which unit may write its result back. Hazards are resolved by stalling:
- a structural conflict or an output (write-after-write) conflict holds the instruction at issue;
- a true (read-after-write) dependency holds the unit before operand read;
- an anti (write-after-read) dependency holds a finished unit before its write.

The scheduler keeps three kinds of state. A per-unit status entry holds the busy bit, the destination, both sources, the producing unit of each source and a ready flag for each source. A per-register producer table records which unit will write each register. The progress of each instruction through issue, operand read, execution and write result is also tracked. The functional units are modelled inside the block as latency counters. Register data, forwarding and branches are outside this block.

With the default parameters there are five units: one integer/load unit (index 0), two multipliers (indices 1 and 2), one adder (index 3) and one divider (index 4). The class encoding is 0 integer, 1 multiply, 2 add and 3 divide. The latencies are 2 cycles for integer, 10 for multiply, 2 for add and 40 for divide.

Top module: `sb_scheduler`

## Requirements
- R1: Immediately after reset, with no valid request, the accept output, all read grants, all write grants and the write destination are 0, and every unit is free.
- R2: An instruction is accepted in the cycle it is presented if a unit of its class is free and no busy unit has the same destination. The chosen unit is the lowest-index free unit of the class. A stalled instruction is held, and no later instruction is accepted before it.
- R3: An instruction whose destination matches the destination of a busy unit is held at issue. It is accepted in the cycle after that unit's write grant.
- R4: A unit receives its read grant in every cycle in which both of its source-ready flags are set and it has not yet read. Several units may be granted in the same cycle. When a unit has no pending producers, the grant comes in the cycle after acceptance.
- R5: A source whose register has a pending producer at issue is not ready. The consumer's read grant comes no earlier than the cycle after the producer's write grant, and exactly then if nothing else blocks it.
- R6: An unblocked unit receives its write grant LAT+1 cycles after its read grant, where LAT is its class latency.
- R7: A finished unit is denied the write grant while another busy unit still has an unread source equal to its destination with that source's ready flag set. It is granted in the cycle after that reader's read grant.
- R8: At most one write grant is given per cycle. When several units are eligible, the lowest index wins and the others wait.
- R9: If an instruction is accepted in the same cycle as the write grant of the unit producing one of its sources, that source is treated as ready. The instruction reads in the next cycle.
- R10: A unit stays busy until its write grant. A second instruction of a single-unit class is accepted in the cycle after the first one's write grant.
- R11: In a cycle with a write grant, the write destination output equals the destination register of the granted unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | An instruction is presented for issue |
| iss_class_i | input | 2 | Operation class: 0 integer, 1 multiply, 2 add, 3 divide |
| iss_dst_i | input | $clog2(REG_COUNT) | Destination register |
| iss_src1_i | input | $clog2(REG_COUNT) | First source register |
| iss_src2_i | input | $clog2(REG_COUNT) | Second source register |
| iss_accept_o | output | 1 | Presented instruction is issued this cycle |
| iss_unit_o | output | $clog2(units) | Unit index chosen for the presented instruction |
| rd_grant_o | output | units | Per-unit operand read grant |
| wb_grant_o | output | units | Per-unit write-back grant, at most one bit set |
| wb_dst_o | output | $clog2(REG_COUNT) | Destination register of the granted write |

## Verification
The bench aims at the cycles where two decisions meet. In one case an instruction issues in the same cycle that its producer writes back. A design that looks up the producer table without a bypass would wait forever on a unit that no longer exists. In another case two multipliers finish together. A design that grants both, or the wrong one first, would show two write grants or a reversed order. A third case has a short integer write racing a slower reader that holds the old value. A design without the write-after-read hold would release the write early and corrupt the reader's operand. Structural and destination conflicts are also run, and a single-cycle slip in the release is exposed as an issue one cycle too early or too late.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_MUL = 2'd1,
      CLS_ADD = 2'd2,
      CLS_DIV = 2'd3
   } op_class_e;

   typedef enum logic [1:0] {
      SLOT_IDLE     = 2'd0,
      SLOT_WAIT_OPS = 2'd1,
      SLOT_EXEC     = 2'd2,
      SLOT_WB_PEND  = 2'd3
   } slot_state_e;

   // Units are laid out class by class: integer, multiply, add, divide.
   function automatic int unit_class(input int idx, input int n_int,
                                     input int n_mul, input int n_add);
      if (idx < n_int)                 return int'(CLS_INT);
      if (idx < n_int + n_mul)         return int'(CLS_MUL);
      if (idx < n_int + n_mul + n_add) return int'(CLS_ADD);
      return int'(CLS_DIV);
   endfunction

   function automatic int class_latency(input int cls, input int l_int,
                                        input int l_mul, input int l_add,
                                        input int l_div);
      case (cls)
         0:       return l_int;
         1:       return l_mul;
         2:       return l_add;
         default: return l_div;
      endcase
   endfunction

endpackage

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
   import sb_pkg::*;
#(
   parameter int RW      = 5,
   parameter int QW      = 3,
   parameter int LATENCY = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_load_i,
   input  logic [RW-1:0] issue_dst_i,
   input  logic [RW-1:0] issue_src1_i,
   input  logic [RW-1:0] issue_src2_i,
   input  logic [QW-1:0] issue_q1_i,
   input  logic [QW-1:0] issue_q2_i,
   input  logic          wb_valid_i,
   input  logic [QW-1:0] wb_tag_i,
   input  logic          wb_grant_i,
   output logic          rd_grant_o,
   output logic          wb_req_o,
   output logic          busy_o,
   output logic [RW-1:0] fi_o,
   output logic [RW-1:0] fj_o,
   output logic [RW-1:0] fk_o,
   output logic          rj_o,
   output logic          rk_o
);
   localparam int CW = $clog2(LATENCY + 1);

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("sb_unit_slot: LATENCY must be at least 1");
      end
   endgenerate

   slot_state_e   state;
   logic [QW-1:0] qj, qk;
   logic [CW-1:0] cnt;

   assign busy_o     = (state != SLOT_IDLE);
   assign rd_grant_o = (state == SLOT_WAIT_OPS) && rj_o && rk_o;
   assign wb_req_o   = (state == SLOT_WB_PEND);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SLOT_IDLE;
         fi_o  <= '0;
         fj_o  <= '0;
         fk_o  <= '0;
         qj    <= '0;
         qk    <= '0;
         rj_o  <= 1'b0;
         rk_o  <= 1'b0;
         cnt   <= '0;
      end else begin
         unique case (state)
            SLOT_IDLE: begin
               if (issue_load_i) begin
                  fi_o  <= issue_dst_i;
                  fj_o  <= issue_src1_i;
                  fk_o  <= issue_src2_i;
                  qj    <= issue_q1_i;
                  qk    <= issue_q2_i;
                  rj_o  <= (issue_q1_i == '0);
                  rk_o  <= (issue_q2_i == '0);
                  state <= SLOT_WAIT_OPS;
               end
            end
            SLOT_WAIT_OPS: begin
               if (rd_grant_o) begin
                  rj_o  <= 1'b0;
                  rk_o  <= 1'b0;
                  cnt   <= CW'(LATENCY);
                  state <= SLOT_EXEC;
               end else begin
                  if (wb_valid_i && (qj == wb_tag_i)) begin
                     qj   <= '0;
                     rj_o <= 1'b1;
                  end
                  if (wb_valid_i && (qk == wb_tag_i)) begin
                     qk   <= '0;
                     rk_o <= 1'b1;
                  end
               end
            end
            SLOT_EXEC: begin
               if (cnt > CW'(1)) cnt <= cnt - CW'(1);
               else              state <= SLOT_WB_PEND;
            end
            SLOT_WB_PEND: begin
               if (wb_grant_i) state <= SLOT_IDLE;
            end
            default: state <= SLOT_IDLE;
         endcase
      end
   end

   // R10: the issue stage only loads a unit that is free
   assert_issue_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      issue_load_i |-> (state == SLOT_IDLE));

   // R4: operands are read once per instruction
   assert_read_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant_o |=> !rd_grant_o);

   // R8: the arbiter only grants a unit whose execution has finished
   assert_grant_finished_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant_i |-> wb_req_o);

   // R6: after a read the unit is counting down its full latency
   assert_latency_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant_o |=> (cnt == CW'(LATENCY)) && !wb_req_o);

endmodule

// File: rtl/sb_result_table.sv
module sb_result_table #(
   parameter int REG_COUNT = 32,
   parameter int QW        = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         set_en_i,
   input  logic [$clog2(REG_COUNT)-1:0] set_reg_i,
   input  logic [QW-1:0]                set_tag_i,
   input  logic                         clr_en_i,
   input  logic [$clog2(REG_COUNT)-1:0] clr_reg_i,
   input  logic [$clog2(REG_COUNT)-1:0] rd1_reg_i,
   input  logic [$clog2(REG_COUNT)-1:0] rd2_reg_i,
   output logic [QW-1:0]                rd1_tag_o,
   output logic [QW-1:0]                rd2_tag_o
);
   logic [QW-1:0] producer [REG_COUNT];

   assign rd1_tag_o = producer[rd1_reg_i];
   assign rd2_tag_o = producer[rd2_reg_i];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < REG_COUNT; r++) producer[r] <= '0;
      end else begin
         if (clr_en_i) producer[clr_reg_i] <= '0;
         if (set_en_i) producer[set_reg_i] <= set_tag_i;
      end
   end

   // R3: a register never gets a second pending producer
   assert_single_producer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en_i |-> (producer[set_reg_i] == '0));

   // R11: a write-back always retires a register that had a producer
   assert_clear_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |-> (producer[clr_reg_i] != '0));

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
   parameter int NUM_UNITS = 5,
   parameter int RW        = 5,
   parameter int QW        = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_UNITS-1:0]          req_i,
   input  logic [NUM_UNITS-1:0]          busy_i,
   input  logic [NUM_UNITS-1:0][RW-1:0]  fi_i,
   input  logic [NUM_UNITS-1:0][RW-1:0]  fj_i,
   input  logic [NUM_UNITS-1:0][RW-1:0]  fk_i,
   input  logic [NUM_UNITS-1:0]          rj_i,
   input  logic [NUM_UNITS-1:0]          rk_i,
   output logic [NUM_UNITS-1:0]          grant_o,
   output logic                          grant_valid_o,
   output logic [QW-1:0]                 grant_tag_o,
   output logic [RW-1:0]                 grant_dst_o
);
   logic [NUM_UNITS-1:0] war_block;
   logic [NUM_UNITS-1:0] eligible;

   // A writer waits while any other unit still needs the old value.
   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_war
         always_comb begin
            war_block[u] = 1'b0;
            for (int v = 0; v < NUM_UNITS; v++) begin
               if (v != u && busy_i[v] &&
                   ((fj_i[v] == fi_i[u] && rj_i[v]) ||
                    (fk_i[v] == fi_i[u] && rk_i[v])))
                  war_block[u] = 1'b1;
            end
         end
      end
   endgenerate

   assign eligible = req_i & ~war_block;

   always_comb begin
      grant_o       = '0;
      grant_valid_o = 1'b0;
      grant_tag_o   = '0;
      grant_dst_o   = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (!grant_valid_o && eligible[u]) begin
            grant_valid_o = 1'b1;
            grant_o[u]    = 1'b1;
            grant_tag_o   = QW'(u + 1);
            grant_dst_o   = fi_i[u];
         end
      end
   end

   // R8: one result bus, one writer per cycle
   assert_single_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R7: a waiting writer stays pending until it is granted
   assert_pending_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[0] && !grant_o[0]) |=> req_i[0]);

endmodule

// File: rtl/sb_scheduler.sv
module sb_scheduler
   import sb_pkg::*;
#(
   parameter int REG_COUNT = 32,
   parameter int NUM_INT   = 1,
   parameter int NUM_MUL   = 2,
   parameter int NUM_ADD   = 1,
   parameter int NUM_DIV   = 1,
   parameter int LAT_INT   = 2,
   parameter int LAT_MUL   = 10,
   parameter int LAT_ADD   = 2,
   parameter int LAT_DIV   = 40
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic                                                iss_valid_i,
   input  logic [1:0]                                          iss_class_i,
   input  logic [$clog2(REG_COUNT)-1:0]                        iss_dst_i,
   input  logic [$clog2(REG_COUNT)-1:0]                        iss_src1_i,
   input  logic [$clog2(REG_COUNT)-1:0]                        iss_src2_i,
   output logic                                                iss_accept_o,
   output logic [$clog2(NUM_INT+NUM_MUL+NUM_ADD+NUM_DIV)-1:0] iss_unit_o,
   output logic [NUM_INT+NUM_MUL+NUM_ADD+NUM_DIV-1:0]         rd_grant_o,
   output logic [NUM_INT+NUM_MUL+NUM_ADD+NUM_DIV-1:0]         wb_grant_o,
   output logic [$clog2(REG_COUNT)-1:0]                        wb_dst_o
);
   localparam int NUM_UNITS = NUM_INT + NUM_MUL + NUM_ADD + NUM_DIV;
   localparam int RW        = $clog2(REG_COUNT);
   localparam int UW        = $clog2(NUM_UNITS);
   localparam int QW        = $clog2(NUM_UNITS + 1);

   generate
      if (REG_COUNT < 2) begin : g_bad_regs
         $error("sb_scheduler: REG_COUNT must be at least 2");
      end
      if (NUM_INT < 1 || NUM_MUL < 1 || NUM_ADD < 1 || NUM_DIV < 1) begin : g_bad_units
         $error("sb_scheduler: every class needs at least one unit");
      end
      if (LAT_INT < 1 || LAT_MUL < 1 || LAT_ADD < 1 || LAT_DIV < 1) begin : g_bad_lat
         $error("sb_scheduler: latencies must be at least 1");
      end
   endgenerate

   logic [NUM_UNITS-1:0][1:0]    unit_cls;
   logic [NUM_UNITS-1:0]         busy, rj, rk, wb_req, issue_load;
   logic [NUM_UNITS-1:0][RW-1:0] fi, fj, fk;
   logic                         wb_valid;
   logic [QW-1:0]                wb_tag;
   logic [QW-1:0]                tbl_q1, tbl_q2, iss_q1, iss_q2;
   logic                         unit_found, waw_hit;
   logic [UW-1:0]                sel_idx;

   // Issue: pick the lowest free unit of the class, refuse on a WAW match.
   always_comb begin
      unit_found = 1'b0;
      sel_idx    = '0;
      waw_hit    = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (!unit_found && !busy[u] && unit_cls[u] == iss_class_i) begin
            unit_found = 1'b1;
            sel_idx    = UW'(u);
         end
         if (busy[u] && fi[u] == iss_dst_i) waw_hit = 1'b1;
      end
   end

   assign iss_accept_o = iss_valid_i && unit_found && !waw_hit;
   assign iss_unit_o   = sel_idx;

   // A producer retiring this cycle no longer counts as pending.
   assign iss_q1 = (wb_valid && tbl_q1 == wb_tag) ? '0 : tbl_q1;
   assign iss_q2 = (wb_valid && tbl_q2 == wb_tag) ? '0 : tbl_q2;

   sb_result_table #(
      .REG_COUNT (REG_COUNT),
      .QW        (QW)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en_i  (iss_accept_o),
      .set_reg_i (iss_dst_i),
      .set_tag_i (QW'(sel_idx) + QW'(1)),
      .clr_en_i  (wb_valid),
      .clr_reg_i (wb_dst_o),
      .rd1_reg_i (iss_src1_i),
      .rd2_reg_i (iss_src2_i),
      .rd1_tag_o (tbl_q1),
      .rd2_tag_o (tbl_q2)
   );

   generate
      for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
         localparam int CLS = unit_class(g, NUM_INT, NUM_MUL, NUM_ADD);
         localparam int LAT = class_latency(CLS, LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV);

         assign unit_cls[g]   = 2'(CLS);
         assign issue_load[g] = iss_accept_o && (sel_idx == UW'(g));

         sb_unit_slot #(
            .RW      (RW),
            .QW      (QW),
            .LATENCY (LAT)
         ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .issue_load_i (issue_load[g]),
            .issue_dst_i  (iss_dst_i),
            .issue_src1_i (iss_src1_i),
            .issue_src2_i (iss_src2_i),
            .issue_q1_i   (iss_q1),
            .issue_q2_i   (iss_q2),
            .wb_valid_i   (wb_valid),
            .wb_tag_i     (wb_tag),
            .wb_grant_i   (wb_grant_o[g]),
            .rd_grant_o   (rd_grant_o[g]),
            .wb_req_o     (wb_req[g]),
            .busy_o       (busy[g]),
            .fi_o         (fi[g]),
            .fj_o         (fj[g]),
            .fk_o         (fk[g]),
            .rj_o         (rj[g]),
            .rk_o         (rk[g])
         );
      end
   endgenerate

   sb_wb_arbiter #(
      .NUM_UNITS (NUM_UNITS),
      .RW        (RW),
      .QW        (QW)
   ) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (wb_req),
      .busy_i        (busy),
      .fi_i          (fi),
      .fj_i          (fj),
      .fk_i          (fk),
      .rj_i          (rj),
      .rk_i          (rk),
      .grant_o       (wb_grant_o),
      .grant_valid_o (wb_valid),
      .grant_tag_o   (wb_tag),
      .grant_dst_o   (wb_dst_o)
   );

   // R2: nothing is issued without a request
   assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_accept_o |-> iss_valid_i);

   // R2: a held instruction stays visible on the next cycle
   assert_hold_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid_i && !iss_accept_o) |=> iss_valid_i);

endmodule

// File: tb/tb_sb_scheduler.sv
module tb_sb_scheduler;
   localparam int NU = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       iss_valid;
   logic [1:0] iss_class;
   logic [4:0] iss_dst, iss_src1, iss_src2;
   logic       iss_accept;
   logic [2:0] iss_unit;
   logic [4:0] rd_grant, wb_grant;
   logic [4:0] wb_dst;

   always #10 clk = ~clk;

   sb_scheduler dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .iss_valid_i  (iss_valid),
      .iss_class_i  (iss_class),
      .iss_dst_i    (iss_dst),
      .iss_src1_i   (iss_src1),
      .iss_src2_i   (iss_src2),
      .iss_accept_o (iss_accept),
      .iss_unit_o   (iss_unit),
      .rd_grant_o   (rd_grant),
      .wb_grant_o   (wb_grant),
      .wb_dst_o     (wb_dst)
   );

   typedef struct {
      bit v;
      int id;
      int cls;
      int dst;
      int s1;
      int s2;
   } ins_t;

   ins_t iq[$];
   int   n_tests = 0, n_fail = 0, cyc = 0, next_id = 0;
   bit   done_flag = 0;
   int   acc_c[64], unit_of[64], rd_c[64], wb_c[64], wbd[64];
   int   occ[NU];
   // behavioural model state: 0 free, 1 waiting operands, 2 executing, 3 finished
   int   m_st[NU], m_fi[NU], m_fj[NU], m_fk[NU], m_qj[NU], m_qk[NU];
   int   m_rj[NU], m_rk[NU], m_cnt[NU];
   int   m_reg[32];

   function automatic int ucls(int u);
      if (u == 0) return 0;
      if (u <= 2) return 1;
      if (u == 3) return 2;
      return 3;
   endfunction

   function automatic int lat(int c);
      case (c)
         0: return 2;
         1: return 10;
         2: return 2;
         default: return 40;
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int push(int cls, int dst, int s1, int s2);
      ins_t t;
      t.v = 1; t.id = next_id; t.cls = cls; t.dst = dst; t.s1 = s1; t.s2 = s2;
      acc_c[next_id] = -1; unit_of[next_id] = -1; rd_c[next_id] = -1;
      wb_c[next_id] = -1; wbd[next_id] = -1;
      next_id++;
      iq.push_back(t);
      return t.id;
   endfunction

   task automatic bubble();
      ins_t t;
      t.v = 0; t.id = 0; t.cls = 0; t.dst = 0; t.s1 = 0; t.s2 = 0;
      iq.push_back(t);
   endtask

   function automatic bit model_idle();
      for (int u = 0; u < NU; u++) if (m_st[u] != 0) return 0;
      return 1;
   endfunction

   task automatic step();
      ins_t cur;
      int   e_acc, e_unit, e_rd, e_wb, e_w, e_dst, f;
      bit   waw, blk;
      @(negedge clk);
      if (iq.size() > 0) cur = iq[0];
      else begin
         cur.v = 0; cur.id = 0; cur.cls = 0; cur.dst = 0; cur.s1 = 0; cur.s2 = 0;
      end
      iss_valid = cur.v;
      iss_class = 2'(cur.cls);
      iss_dst   = 5'(cur.dst);
      iss_src1  = 5'(cur.s1);
      iss_src2  = 5'(cur.s2);
      #1;
      e_acc = 0; e_unit = 0; e_rd = 0; e_wb = 0; e_w = -1; e_dst = 0;
      if (cur.v) begin
         f = -1; waw = 0;
         for (int u = 0; u < NU; u++) begin
            if (f < 0 && m_st[u] == 0 && ucls(u) == cur.cls) f = u;
            if (m_st[u] != 0 && m_fi[u] == cur.dst) waw = 1;
         end
         if (f >= 0 && !waw) begin e_acc = 1; e_unit = f; end
      end
      for (int u = 0; u < NU; u++)
         if (m_st[u] == 1 && m_rj[u] != 0 && m_rk[u] != 0) e_rd |= (1 << u);
      for (int u = 0; u < NU; u++) begin
         if (e_w < 0 && m_st[u] == 3) begin
            blk = 0;
            for (int v = 0; v < NU; v++)
               if (v != u && m_st[v] != 0 &&
                   ((m_fj[v] == m_fi[u] && m_rj[v] != 0) ||
                    (m_fk[v] == m_fi[u] && m_rk[v] != 0))) blk = 1;
            if (!blk) e_w = u;
         end
      end
      if (e_w >= 0) begin e_wb = 1 << e_w; e_dst = m_fi[e_w]; end

      check("R2", "issue accept", int'(iss_accept), e_acc);
      if (e_acc != 0) check("R2", "issue unit", int'(iss_unit), e_unit);
      check("R4", "read grants", int'(rd_grant), e_rd);
      check("R8", "write grants", int'(wb_grant), e_wb);
      if (e_w >= 0) check("R11", "write destination", int'(wb_dst), e_dst);

      // event log from the ports
      if (iss_accept && cur.v && int'(iss_unit) < NU) begin
         acc_c[cur.id] = cyc; unit_of[cur.id] = int'(iss_unit);
         occ[iss_unit] = cur.id;
      end
      for (int u = 0; u < NU; u++) begin
         if (rd_grant[u]) rd_c[occ[u]] = cyc;
         if (wb_grant[u]) begin wb_c[occ[u]] = cyc; wbd[occ[u]] = int'(wb_dst); end
      end

      // model advance
      for (int u = 0; u < NU; u++) begin
         if ((e_rd >> u) & 1) begin
            m_rj[u] = 0; m_rk[u] = 0; m_st[u] = 2; m_cnt[u] = lat(ucls(u));
         end else if (m_st[u] == 2) begin
            if (m_cnt[u] > 1) m_cnt[u]--; else m_st[u] = 3;
         end
      end
      if (e_w >= 0) begin
         m_st[e_w] = 0;
         m_reg[m_fi[e_w]] = -1;
         for (int v = 0; v < NU; v++) begin
            if (m_st[v] == 1 && m_qj[v] == e_w) begin m_qj[v] = -1; m_rj[v] = 1; end
            if (m_st[v] == 1 && m_qk[v] == e_w) begin m_qk[v] = -1; m_rk[v] = 1; end
         end
      end
      if (e_acc != 0) begin
         m_st[e_unit] = 1; m_fi[e_unit] = cur.dst; m_fj[e_unit] = cur.s1;
         m_fk[e_unit] = cur.s2;
         m_qj[e_unit] = m_reg[cur.s1]; m_qk[e_unit] = m_reg[cur.s2];
         m_rj[e_unit] = (m_qj[e_unit] < 0); m_rk[e_unit] = (m_qk[e_unit] < 0);
         m_reg[cur.dst] = e_unit;
      end
      if (iq.size() > 0 && (!cur.v || e_acc != 0)) void'(iq.pop_front());
      cyc++;
   endtask

   task automatic drain();
      do step(); while (iq.size() > 0 || !model_idle());
      repeat (2) step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_tests++; n_fail++;
         $display("FAIL R5 watchdog: actual %0d cycles without draining expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int a, m, d, p, c, i, ma, mb, d1, d2;
      for (int u = 0; u < NU; u++) begin m_st[u] = 0; occ[u] = 0; end
      for (int r = 0; r < 32; r++) m_reg[r] = -1;
      rst_n = 1'b0; iss_valid = 1'b0; iss_class = '0;
      iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1", "accept after reset", int'(iss_accept), 0);
      check("R1", "read grants after reset", int'(rd_grant), 0);
      check("R1", "write grants after reset", int'(wb_grant), 0);
      check("R1", "write destination after reset", int'(wb_dst), 0);

      // independent add, multiply, divide: read next cycle, latency LAT+1
      a = push(2, 24, 1, 2); m = push(1, 25, 3, 4); d = push(3, 26, 5, 6);
      drain();
      check("R1", "first issue on fresh units", acc_c[m] - acc_c[a], 1);
      check("R4", "add reads after issue", rd_c[a], acc_c[a] + 1);
      check("R4", "mul reads after issue", rd_c[m], acc_c[m] + 1);
      check("R6", "add write latency", wb_c[a] - rd_c[a], 3);
      check("R6", "mul write latency", wb_c[m] - rd_c[m], 11);
      check("R6", "div write latency", wb_c[d] - rd_c[d], 41);
      check("R11", "div write destination", wbd[d], 26);

      // true dependency
      p = push(1, 4, 1, 2); c = push(2, 5, 4, 3);
      drain();
      check("R5", "consumer read after producer write", rd_c[c], wb_c[p] + 1);
      check("R2", "dependent consumer issues without stall", acc_c[c], acc_c[p] + 1);

      // output dependency
      p = push(1, 6, 1, 2); c = push(2, 6, 3, 4);
      drain();
      check("R3", "same destination issues after write", acc_c[c], wb_c[p] + 1);

      // anti dependency: short integer write to r12 waits for adder to read r12
      m = push(1, 10, 1, 2); a = push(2, 11, 10, 12); i = push(0, 12, 1, 2);
      drain();
      check("R7", "writer released after reader reads", wb_c[i], rd_c[a] + 1);
      check("R7", "writer held beyond its latency", wb_c[i] - rd_c[i], 11);

      // two multipliers waiting on one producer, finishing together
      p = push(0, 16, 1, 2); ma = push(1, 17, 16, 1); mb = push(1, 18, 16, 2);
      drain();
      check("R2", "first multiply on lowest unit", unit_of[ma], 1);
      check("R2", "second multiply on next unit", unit_of[mb], 2);
      check("R4", "parallel read grants", rd_c[mb], rd_c[ma]);
      check("R8", "lower index writes first", wb_c[mb], wb_c[ma] + 1);

      // issue in the producer's write cycle
      p = push(2, 19, 1, 2); bubble(); bubble(); bubble(); c = push(1, 20, 19, 1);
      drain();
      check("R9", "setup: issue meets producer write", acc_c[c], wb_c[p]);
      check("R9", "source seen ready at issue", rd_c[c], acc_c[c] + 1);

      // structural hazard on the single divider, then in-order issue
      d1 = push(3, 21, 1, 2); d2 = push(3, 22, 3, 4); a = push(2, 23, 5, 6);
      drain();
      check("R10", "divider reused after write", acc_c[d2], wb_c[d1] + 1);
      check("R2", "younger add waits behind stalled divide", acc_c[a], acc_c[d2] + 1);

      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule